// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens passively to the two wires of an I2C bus, which are sampled by a much faster system clock. It never drives either line. Both lines pass through a multi-flop synchroniser. The monitor then compares each synchronised sample with the one before it. From that comparison it recognises START and STOP conditions and counts the bits of each frame.

Each frame is nine SCL cycles long: eight data bits, most significant bit first, followed by one acknowledge bit. A bit is sampled on the SCL rising edge and committed on the following falling edge. The first byte after any START is the address byte (seven address bits plus the read/write bit). Every later byte is a data byte.

The monitor reports START, STOP, completed bytes, ACK and NACK as single-cycle pulses, and keeps a bus-busy flag. A START or STOP that lands inside a frame is reported as a bus error, together with its bit position. The monitor also reports SDA activity that breaks the rule that data stays stable while SCL is high but does not form a proper condition.

Top module: `i2c_line_watch`

## Requirements
- R1: After reset, busy_o, byte_o, byte_addr_o, err_code_o and err_pos_o are 0, and every pulse output is low.
- R2: When SDA falls while SCL is high in both the old and the new sample, start_p pulses for one cycle and busy_o goes to 1.
- R3: When SDA rises while SCL is high and busy_o is 1, stop_p pulses and busy_o goes to 0.
- R4: While busy_o is 1, each bit is the SDA level at an SCL rising edge and is committed on the next SCL falling edge. On the eighth committed bit, byte_p pulses and byte_o holds the bits, first received in bit 7. byte_addr_o is 1 for the first byte after a START and 0 for every later byte.
- R5: The ninth committed bit of a frame pulses ack_p if SDA was 0 and nack_p if SDA was 1. The frame count then returns to 0.
- R6: A START with zero committed bits in the current frame (a repeated START) is legal. It raises no error and makes the next byte an address byte.
- R7: A START with 1 to 8 committed bits in the current frame pulses err_p in the same cycle as start_p, with err_code_o = 1 and err_pos_o = the number of committed bits. A new frame then begins.
- R8: A STOP with 1 to 8 committed bits in the current frame pulses err_p in the same cycle as stop_p, with err_code_o = 2 and err_pos_o = the number of committed bits. busy_o goes to 0.
- R9: err_p pulses with err_code_o = 3 in two cases. The first is an SDA rise with SCL high while busy_o is 0; this case produces no stop_p. The second is an SDA change in the same sample as an SCL fall while busy_o is 1; here err_pos_o reports the bits committed before that edge.
- R10: While busy_o is 0, SCL toggling produces no byte_p, ack_p, nack_p or err_p.
- R11: start_p and stop_p are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| start_p | output | 1 | START condition pulse |
| stop_p | output | 1 | STOP condition pulse |
| busy_o | output | 1 | Bus held between START and STOP |
| byte_p | output | 1 | Byte completed pulse |
| byte_o | output | BYTE_W | Last completed byte |
| byte_addr_o | output | 1 | Last byte was the address byte |
| ack_p | output | 1 | Acknowledge bit was low |
| nack_p | output | 1 | Acknowledge bit was high |
| err_p | output | 1 | Bus error pulse |
| err_code_o | output | 2 | 1 misplaced START, 2 misplaced STOP, 3 stray SDA change |
| err_pos_o | output | CNT_W | Committed bits in the frame when the error occurred |

## Verification
A misplaced condition must raise its condition pulse and the error pulse in the same cycle. The bench provokes this by cutting a frame after three bits with a repeated START, and after five bits with a STOP. For each case it counts the cycles in which err_p coincides with start_p or stop_p, and checks the reported code and position. A second overlap is an SDA change on the same sample as an SCL fall. That edge both commits a bit and raises the stray error, and the following STOP must then be counted as misplaced at position 1.

// File: rtl/i2cw_pkg.sv
`timescale 1ns/1ps
package i2cw_pkg;

   typedef enum logic [1:0] {
      ERR_NONE      = 2'd0,
      ERR_MIS_START = 2'd1,
      ERR_MIS_STOP  = 2'd2,
      ERR_STRAY     = 2'd3
   } err_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic skew;
      logic scl_rise;
      logic scl_fall;
      logic sda;
   } cond_t;

endpackage

// File: rtl/i2cw_sync.sv
`timescale 1ns/1ps
module i2cw_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cw_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2cw_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st[s] <= {WIDTH{RST_LVL}};
         else if (s == 0)
            st[s] <= d_i;
         else
            st[s] <= st[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = st[STAGES-1];

endmodule

// File: rtl/i2cw_cond.sv
`timescale 1ns/1ps
module i2cw_cond
   import i2cw_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_s,
   input  logic  sda_s,
   output cond_t cnd_o
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      cnd_o.scl_rise = scl_s & ~scl_q;
      cnd_o.scl_fall = ~scl_s & scl_q;
      cnd_o.start    = scl_s & scl_q & sda_q & ~sda_s;
      cnd_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
      cnd_o.skew     = scl_q & ~scl_s & (sda_s ^ sda_q);
      cnd_o.sda      = sda_s;
   end

endmodule

// File: rtl/i2cw_frame.sv
`timescale 1ns/1ps
module i2cw_frame
   import i2cw_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cond_t             cnd_i,
   output logic              start_p,
   output logic              stop_p,
   output logic              busy_o,
   output logic              byte_p,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_addr_o,
   output logic              ack_p,
   output logic              nack_p,
   output logic              err_p,
   output logic [1:0]        err_code_o,
   output logic [CNT_W-1:0]  err_pos_o
);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("i2cw_frame: BYTE_W must be at least 2");
   end
   if ((1 << CNT_W) <= BYTE_W) begin : g_bad_cnt
      $error("i2cw_frame: CNT_W too narrow for BYTE_W+1 bits");
   end

   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BYTE_W);

   logic              busy_q, have_q, smp_q, first_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] shr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         have_q      <= 1'b0;
         smp_q       <= 1'b0;
         first_q     <= 1'b0;
         cnt_q       <= '0;
         shr_q       <= '0;
         start_p     <= 1'b0;
         stop_p      <= 1'b0;
         byte_p      <= 1'b0;
         byte_o      <= '0;
         byte_addr_o <= 1'b0;
         ack_p       <= 1'b0;
         nack_p      <= 1'b0;
         err_p       <= 1'b0;
         err_code_o  <= ERR_NONE;
         err_pos_o   <= '0;
      end else begin
         start_p <= 1'b0;
         stop_p  <= 1'b0;
         byte_p  <= 1'b0;
         ack_p   <= 1'b0;
         nack_p  <= 1'b0;
         err_p   <= 1'b0;
         if (cnd_i.start) begin
            start_p <= 1'b1;
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            have_q  <= 1'b0;
            first_q <= 1'b1;
            if (busy_q && cnt_q != '0) begin
               err_p      <= 1'b1;
               err_code_o <= ERR_MIS_START;
               err_pos_o  <= cnt_q;
            end
         end else if (cnd_i.stop) begin
            have_q <= 1'b0;
            cnt_q  <= '0;
            if (busy_q) begin
               stop_p <= 1'b1;
               busy_q <= 1'b0;
               if (cnt_q != '0) begin
                  err_p      <= 1'b1;
                  err_code_o <= ERR_MIS_STOP;
                  err_pos_o  <= cnt_q;
               end
            end else begin
               err_p      <= 1'b1;
               err_code_o <= ERR_STRAY;
               err_pos_o  <= '0;
            end
         end else if (busy_q) begin
            if (cnd_i.scl_rise) begin
               have_q <= 1'b1;
               smp_q  <= cnd_i.sda;
            end
            if (cnd_i.scl_fall) begin
               if (cnd_i.skew) begin
                  err_p      <= 1'b1;
                  err_code_o <= ERR_STRAY;
                  err_pos_o  <= cnt_q;
               end
               if (have_q) begin
                  have_q <= 1'b0;
                  if (cnt_q == ACK_POS) begin
                     cnt_q   <= '0;
                     first_q <= 1'b0;
                     ack_p   <= ~smp_q;
                     nack_p  <= smp_q;
                  end else begin
                     shr_q <= {shr_q[BYTE_W-2:0], smp_q};
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == LAST_DATA) begin
                        byte_p      <= 1'b1;
                        byte_o      <= {shr_q[BYTE_W-2:0], smp_q};
                        byte_addr_o <= first_q;
                     end
                  end
               end
            end
         end
      end
   end

   assign busy_o = busy_q;

   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> start_p);

   p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> stop_p);

   p_ack_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_p || nack_p) |-> (busy_o && !$past(byte_p)));

   p_mis_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_p && err_code_o == ERR_MIS_START) |-> (start_p && err_pos_o != '0));

   p_mis_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_p && err_code_o == ERR_MIS_STOP) |-> (stop_p && !busy_o && err_pos_o != '0));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o)) |-> !(byte_p || ack_p || nack_p));

   p_start_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !start_p);

   p_stop_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !stop_p);

endmodule

// File: rtl/i2c_line_watch.sv
`timescale 1ns/1ps
module i2c_line_watch
   import i2cw_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              start_p,
   output logic              stop_p,
   output logic              busy_o,
   output logic              byte_p,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_addr_o,
   output logic              ack_p,
   output logic              nack_p,
   output logic              err_p,
   output logic [1:0]        err_code_o,
   output logic [CNT_W-1:0]  err_pos_o
);

   logic [1:0] line_s;
   cond_t      cnd;

   i2cw_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_LVL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (line_s)
   );

   i2cw_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (line_s[1]),
      .sda_s (line_s[0]),
      .cnd_o (cnd)
   );

   i2cw_frame #(
      .BYTE_W (BYTE_W),
      .CNT_W  (CNT_W)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnd_i       (cnd),
      .start_p     (start_p),
      .stop_p      (stop_p),
      .busy_o      (busy_o),
      .byte_p      (byte_p),
      .byte_o      (byte_o),
      .byte_addr_o (byte_addr_o),
      .ack_p       (ack_p),
      .nack_p      (nack_p),
      .err_p       (err_p),
      .err_code_o  (err_code_o),
      .err_pos_o   (err_pos_o)
   );

   p_start_stop_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_p && stop_p));

   p_err_coded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_p |-> (err_code_o != 2'd0));

endmodule

// File: tb/tb_i2c_line_watch.sv
`timescale 1ns/1ps
module tb_i2c_line_watch;

   localparam int HOLD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       start_p, stop_p, busy_o, byte_p, byte_addr_o;
   logic       ack_p, nack_p, err_p;
   logic [7:0] byte_o;
   logic [1:0] err_code_o;
   logic [3:0] err_pos_o;

   int checks = 0;
   int fails  = 0;

   int n_start, n_stop, n_byte, n_addr, n_ack, n_nack, n_err, n_both;
   int n_code [4];
   int last_byte, last_pos, last_code;

   always #2.5 clk = ~clk;

   i2c_line_watch dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda),
      .start_p     (start_p),
      .stop_p      (stop_p),
      .busy_o      (busy_o),
      .byte_p      (byte_p),
      .byte_o      (byte_o),
      .byte_addr_o (byte_addr_o),
      .ack_p       (ack_p),
      .nack_p      (nack_p),
      .err_p       (err_p),
      .err_code_o  (err_code_o),
      .err_pos_o   (err_pos_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_p) n_start++;
         if (stop_p)  n_stop++;
         if (byte_p) begin
            n_byte++;
            last_byte = byte_o;
            if (byte_addr_o) n_addr++;
         end
         if (ack_p)  n_ack++;
         if (nack_p) n_nack++;
         if (err_p) begin
            n_err++;
            n_code[err_code_o]++;
            last_code = err_code_o;
            last_pos  = err_pos_o;
            if (start_p || stop_p) n_both++;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr();
      @(posedge clk);
      n_start = 0; n_stop = 0; n_byte = 0; n_addr = 0;
      n_ack = 0; n_nack = 0; n_err = 0; n_both = 0;
      for (int i = 0; i < 4; i++) n_code[i] = 0;
      last_byte = -1; last_pos = -1; last_code = -1;
   endtask

   task automatic gap();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic drv_start();
      sda = 1'b1; scl = 1'b1; gap();
      sda = 1'b0; gap();
      scl = 1'b0; gap();
   endtask

   task automatic drv_rstart();
      scl = 1'b0; sda = 1'b1; gap();
      scl = 1'b1; gap();
      sda = 1'b0; gap();
      scl = 1'b0; gap();
   endtask

   task automatic drv_stop();
      scl = 1'b0; sda = 1'b0; gap();
      scl = 1'b1; gap();
      sda = 1'b1; gap();
   endtask

   task automatic drv_bit(input logic b);
      scl = 1'b0; sda = b; gap();
      scl = 1'b1; gap();
      scl = 1'b0; gap();
   endtask

   task automatic send_byte(input logic [7:0] b, input logic a);
      for (int i = 7; i >= 0; i--) drv_bit(b[i]);
      drv_bit(a);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   // R1: reset state
   task automatic t_reset();
      @(negedge clk);
      chk("R1 busy",     busy_o, 0);
      chk("R1 byte",     byte_o, 0);
      chk("R1 addr",     byte_addr_o, 0);
      chk("R1 errcode",  err_code_o, 0);
      chk("R1 errpos",   err_pos_o, 0);
      chk("R1 pulses",   {start_p, stop_p, byte_p, ack_p, nack_p, err_p}, 0);
   endtask

   // R2 R3 R4 R5: plain write of address and one data byte
   task automatic t_write();
      clr();
      drv_start();
      chk("R2 busy set", busy_o, 1);
      chk("R2 start",    n_start, 1);
      send_byte(8'hA4, 1'b0);
      chk("R4 addr byte", last_byte, 8'hA4);
      chk("R4 addr flag", n_addr, 1);
      send_byte(8'h3C, 1'b0);
      drv_stop();
      settle();
      chk("R4 data byte", last_byte, 8'h3C);
      chk("R4 bytes",     n_byte, 2);
      chk("R4 one addr",  n_addr, 1);
      chk("R5 acks",      n_ack, 2);
      chk("R5 nacks",     n_nack, 0);
      chk("R3 stop",      n_stop, 1);
      chk("R3 busy clr",  busy_o, 0);
      chk("R6 no err",    n_err, 0);
   endtask

   // R5 R6: nack then repeated start at bit 0
   task automatic t_nack_rstart();
      clr();
      drv_start();
      send_byte(8'h55, 1'b1);
      drv_rstart();
      send_byte(8'h81, 1'b0);
      drv_stop();
      settle();
      chk("R5 nack",      n_nack, 1);
      chk("R5 ack",       n_ack, 1);
      chk("R6 starts",    n_start, 2);
      chk("R6 no err",    n_err, 0);
      chk("R6 addr x2",   n_addr, 2);
      chk("R6 last byte", last_byte, 8'h81);
   endtask

   // R7: start after 3 committed bits
   task automatic t_mis_start();
      clr();
      drv_start();
      drv_bit(1'b1); drv_bit(1'b0); drv_bit(1'b1);
      drv_rstart();
      settle();
      chk("R7 err",      n_err, 1);
      chk("R7 code",     last_code, 1);
      chk("R7 pos",      last_pos, 3);
      chk("R7 same cyc", n_both, 1);
      send_byte(8'h0F, 1'b0);
      drv_stop();
      settle();
      chk("R7 restart byte", last_byte, 8'h0F);
      chk("R7 restart addr", n_addr, 1);
      chk("R7 total err",    n_err, 1);
   endtask

   // R8: stop after 5 committed bits
   task automatic t_mis_stop();
      clr();
      drv_start();
      for (int i = 0; i < 5; i++) drv_bit(i[0]);
      drv_stop();
      settle();
      chk("R8 code",     last_code, 2);
      chk("R8 pos",      last_pos, 5);
      chk("R8 same cyc", n_both, 1);
      chk("R8 stop",     n_stop, 1);
      chk("R8 busy",     busy_o, 0);
      chk("R8 no byte",  n_byte, 0);
   endtask

   // R9: stray stop while idle
   task automatic t_stray_idle();
      clr();
      scl = 1'b0; gap();
      sda = 1'b0; gap();
      scl = 1'b1; gap();
      sda = 1'b1; gap();
      settle();
      chk("R9 idle err",  n_code[3], 1);
      chk("R9 idle pos",  last_pos, 0);
      chk("R9 no stop",   n_stop, 0);
      chk("R9 busy",      busy_o, 0);
   endtask

   // R9 R8: SDA change on the SCL falling sample
   task automatic t_skew();
      clr();
      drv_start();
      scl = 1'b0; sda = 1'b1; gap();
      scl = 1'b1; gap();
      scl = 1'b0; sda = 1'b0; gap();
      drv_stop();
      settle();
      chk("R9 skew err",   n_code[3], 1);
      chk("R8 after skew", n_code[2], 1);
      chk("R8 pos 1",      last_pos, 1);
      chk("R9 total",      n_err, 2);
   endtask

   // R10: SCL toggling while idle
   task automatic t_idle_toggle();
      clr();
      for (int i = 0; i < 12; i++) begin
         scl = 1'b0; sda = i[1]; gap();
         scl = 1'b1; gap();
      end
      sda = 1'b1; gap();
      settle();
      chk("R10 bytes", n_byte, 0);
      chk("R10 acks",  n_ack + n_nack, 0);
      chk("R10 errs",  n_err, 0);
      chk("R10 busy",  busy_o, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write();
      t_nack_rstart();
      t_mis_start();
      t_mis_stop();
      t_stray_idle();
      t_skew();
      t_idle_toggle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule